// File: doc/BRIEF.md
# Floating-Point Operand Unpack and Classify

This block takes one raw operand, up to 128 bits wide, together with a type select. The select names a signed 32-bit integer, a single, a double or a 128-bit extended value. The block turns that operand into one common internal form that the arithmetic stages downstream can consume without knowing the source format. The internal form is made of the following fields:

- a sign bit
- a signed, unbiased exponent
- a 128-bit mantissa, left-aligned, with its leading one written out explicitly at bit 124
- a sticky bit, which is always cleared
- a class code
- an invalid-operation flag

Subnormal values and nonzero integers are normalized, so the leading one always lands at bit 124. A signalling NaN is made quiet, and the invalid flag is raised for it. A type select that names no format is reported on an error output; the block does not stop.

The operand is presented on the bus with its most significant 32-bit word in bits 127:96. A single or an integer uses bits 127:96 only. A double uses bits 127:64, and an extended value uses the whole bus. Every float format is packed as sign, then biased exponent, then fraction, reading from bit 127 downward. The exponent and fraction widths are 8/23 for single, 11/52 for double and 15/112 for extended. The result is registered, so it appears one clock after the operand is presented.

Top module: `fp_operand_unpack`

## Requirements
- R1: When `inValid` is high at a rising edge, all result outputs load at that edge and `outValid` goes high. When `inValid` is low, `outValid` goes low and every other result output keeps its value.
- R2: The type codes on `fmtSel` are 0 for integer, 1 for single, 2 for double and 3 for extended. For every legal code, `outSign` equals `operand[127]`. `outSticky` is always 0.
- R3: The class codes are 0 zero, 1 number, 2 infinity, 3 quiet NaN and 4 signalling NaN. A float with a zero exponent field and a zero fraction gives class 0, and so does an integer equal to 0. In both cases the exponent and the mantissa outputs are 0.
- R4: A normal float gives class 1. Its exponent is the exponent field minus the bias (127, 1023 or 16383). Its mantissa has bit 124 set, the fraction placed from bit 123 downward, and every other bit 0.
- R5: A float with a zero exponent field and a nonzero fraction gives class 1. It gets no implied one. Its value is taken as 1 minus the bias, and it is shifted left until its top set bit sits at bit 124. The exponent drops by one for each position shifted.
- R6: A float with an all-ones exponent field and a zero fraction gives class 2, with the exponent and mantissa outputs 0.
- R7: A float with an all-ones exponent field and a nonzero fraction whose top bit is 1 gives class 3. The fraction is copied from bit 123 downward without normalization. Bit 124 is 0, the exponent is 0 and `outInvalid` is 0.
- R8: A NaN whose fraction top bit is 0 gives class 4. It has `outInvalid` set to 1 and mantissa bit 123 set, and is otherwise laid out as in R7.
- R9: A nonzero integer is converted to sign and magnitude, with 0x80000000 taken as magnitude 2^31. It gives class 1, an exponent equal to the index of the magnitude's top set bit, and the magnitude placed with that bit at mantissa bit 124.
- R10: A `fmtSel` value of 4 to 7 sets `outFmtErr`. The class is 0, and the sign, exponent, mantissa and invalid outputs are all 0. `outFmtErr` is 0 for every legal code.
- R11: While reset is applied, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand present this cycle |
| fmtSel | input | 3 | Source type select |
| operand | input | 128 | Raw operand, most significant word in bits 127:96 |
| outValid | output | 1 | Result registered from a presented operand |
| outSign | output | 1 | Sign of the result |
| outExp | output | 18 | Unbiased exponent, two's complement |
| outMant | output | 128 | Mantissa, leading one at bit 124 |
| outSticky | output | 1 | Sticky bit, always cleared |
| outClass | output | 3 | Class code |
| outInvalid | output | 1 | Invalid-operation flag (signalling NaN input) |
| outFmtErr | output | 1 | Illegal type select |

## Verification
The assertions take as given that the operand, the select and the valid input settle between clock edges. They also take it that reset is applied before the first operand, because each one is gated by the valid output of the previous cycle. Any bit pattern and any select value, legal or not, is allowed, so the random stimulus draws all four operand words freely and sometimes draws an illegal select. It also forces the exponent field to zero or to all ones often enough that subnormal, infinity and NaN cases show up alongside normal values. Directed vectors cover the extremes of each format and the most negative integer.

// File: rtl/fpu_unpack_pkg.sv
package fpu_unpack_pkg;
  localparam int MantW     = 128;
  localparam int LeadPos   = 124;
  localparam int HeadRoom  = MantW - 1 - LeadPos;
  localparam int ExpW      = 18;
  localparam int IntW      = 32;
  localparam int SglExpW   = 8;
  localparam int SglFracW  = 23;
  localparam int DblExpW   = 11;
  localparam int DblFracW  = 52;
  localparam int ExtExpW   = 15;
  localparam int ExtFracW  = 112;
  localparam int ExpFieldW = ExtExpW;
  localparam int SglBias   = (1 << (SglExpW - 1)) - 1;
  localparam int DblBias   = (1 << (DblExpW - 1)) - 1;
  localparam int ExtBias   = (1 << (ExtExpW - 1)) - 1;
  localparam int IntPreset = LeadPos - (MantW - IntW);
  localparam int CntW      = $clog2(MantW + 1);

  localparam logic [2:0] FMT_INT = 3'd0;
  localparam logic [2:0] FMT_SGL = 3'd1;
  localparam logic [2:0] FMT_DBL = 3'd2;
  localparam logic [2:0] FMT_EXT = 3'd3;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } clsT;

  typedef struct packed {
    logic loadInt;
    logic loadFrac;
    logic addLead;
    logic setQuiet;
    logic doNorm;
    logic expNormal;
    logic expSub;
    logic raiseInv;
    logic selErr;
    clsT  cls;
  } unpackStrobeT;
endpackage

// File: rtl/fp_unpack_lzc.sv
module fp_unpack_lzc #(
  parameter int W = 128,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  always_comb begin
    logic found;
    found = 1'b0;
    count = CW'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && vec[i]) begin
        count = CW'(W - 1 - i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fp_unpack_ctrl.sv
module fp_unpack_ctrl
  import fpu_unpack_pkg::*;
(
  input  logic [2:0]           fmtSel,
  input  logic [ExpFieldW-1:0] expField,
  input  logic                 fracNonZero,
  input  logic                 quietBit,
  input  logic                 intNonZero,
  output unpackStrobeT         strobe
);
  logic [ExpFieldW-1:0] expMax;

  always_comb begin
    case (fmtSel)
      FMT_SGL: expMax = ExpFieldW'((1 << SglExpW) - 1);
      FMT_DBL: expMax = ExpFieldW'((1 << DblExpW) - 1);
      default: expMax = ExpFieldW'((1 << ExtExpW) - 1);
    endcase
  end

  always_comb begin
    strobe = '0;
    strobe.cls = CLS_ZERO;
    if (fmtSel > FMT_EXT) begin
      strobe.selErr = 1'b1;
    end else if (fmtSel == FMT_INT) begin
      if (intNonZero) begin
        strobe.loadInt = 1'b1;
        strobe.doNorm  = 1'b1;
        strobe.cls     = CLS_NUM;
      end
    end else if (expField == '0) begin
      if (fracNonZero) begin
        strobe.loadFrac = 1'b1;
        strobe.expSub   = 1'b1;
        strobe.doNorm   = 1'b1;
        strobe.cls      = CLS_NUM;
      end
    end else if (expField == expMax) begin
      if (!fracNonZero) begin
        strobe.cls = CLS_INF;
      end else if (quietBit) begin
        strobe.loadFrac = 1'b1;
        strobe.cls      = CLS_QNAN;
      end else begin
        strobe.loadFrac = 1'b1;
        strobe.setQuiet = 1'b1;
        strobe.raiseInv = 1'b1;
        strobe.cls      = CLS_SNAN;
      end
    end else begin
      strobe.loadFrac  = 1'b1;
      strobe.addLead   = 1'b1;
      strobe.expNormal = 1'b1;
      strobe.cls       = CLS_NUM;
    end
  end
endmodule

// File: rtl/fp_unpack_dp.sv
module fp_unpack_dp
  import fpu_unpack_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [2:0]           fmtSel,
  input  logic [MantW-1:0]     operand,
  input  unpackStrobeT         strobe,
  output logic [ExpFieldW-1:0] expField,
  output logic                 fracNonZero,
  output logic                 quietBit,
  output logic                 intNonZero,
  output logic                 outValid,
  output logic                 outSign,
  output logic [ExpW-1:0]      outExp,
  output logic [MantW-1:0]     outMant,
  output logic [2:0]           outClass,
  output logic                 outInvalid,
  output logic                 outFmtErr
);
  logic [MantW-1:0]       alignedFrac, preMant, normMant, nextMant;
  logic signed [ExpW-1:0] bias, preExp, shiftAmt, nextExp;
  logic [IntW-1:0]        intWord, intMag;
  logic [CntW-1:0]        lzCount;
  logic [7:0]             leftAmt, rightAmt;

  always_comb begin
    alignedFrac = '0;
    expField    = '0;
    bias        = '0;
    case (fmtSel)
      FMT_SGL: begin
        expField = ExpFieldW'(operand[MantW-2 -: SglExpW]);
        alignedFrac[LeadPos-1 -: SglFracW] = operand[MantW-2-SglExpW -: SglFracW];
        bias = ExpW'(SglBias);
      end
      FMT_DBL: begin
        expField = ExpFieldW'(operand[MantW-2 -: DblExpW]);
        alignedFrac[LeadPos-1 -: DblFracW] = operand[MantW-2-DblExpW -: DblFracW];
        bias = ExpW'(DblBias);
      end
      FMT_EXT: begin
        expField = ExpFieldW'(operand[MantW-2 -: ExtExpW]);
        alignedFrac[LeadPos-1 -: ExtFracW] = operand[MantW-2-ExtExpW -: ExtFracW];
        bias = ExpW'(ExtBias);
      end
      default: ;
    endcase
  end

  assign fracNonZero = |alignedFrac;
  assign quietBit    = alignedFrac[LeadPos-1];
  assign intWord     = operand[MantW-1 -: IntW];
  assign intNonZero  = |intWord;
  assign intMag      = intWord[IntW-1] ? (~intWord + 1'b1) : intWord;

  always_comb begin
    preMant = '0;
    if (strobe.loadInt)  preMant = {intMag, {(MantW-IntW){1'b0}}};
    if (strobe.loadFrac) preMant = alignedFrac;
    if (strobe.addLead)  preMant[LeadPos] = 1'b1;
    if (strobe.setQuiet) preMant[LeadPos-1] = 1'b1;
    preExp = '0;
    if (strobe.loadInt)   preExp = ExpW'(IntPreset);
    if (strobe.expNormal) preExp = signed'(ExpW'(expField)) - bias;
    if (strobe.expSub)    preExp = signed'(ExpW'(1)) - bias;
  end

  fp_unpack_lzc #(.W(MantW)) lzc_i (.vec(preMant), .count(lzCount));

  always_comb begin
    shiftAmt = signed'(ExpW'(lzCount)) - signed'(ExpW'(HeadRoom));
    leftAmt  = 8'(shiftAmt);
    rightAmt = 8'(-shiftAmt);
    normMant = shiftAmt[ExpW-1] ? (preMant >> rightAmt) : (preMant << leftAmt);
    nextMant = strobe.doNorm ? normMant : preMant;
    nextExp  = strobe.doNorm ? (preExp - shiftAmt) : preExp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outSign    <= 1'b0;
      outExp     <= '0;
      outMant    <= '0;
      outClass   <= CLS_ZERO;
      outInvalid <= 1'b0;
      outFmtErr  <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outSign    <= operand[MantW-1] & ~strobe.selErr;
        outExp     <= nextExp;
        outMant    <= nextMant;
        outClass   <= strobe.cls;
        outInvalid <= strobe.raiseInv;
        outFmtErr  <= strobe.selErr;
      end
    end
  end

  // R8
  snan_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outInvalid == (outClass == CLS_SNAN)));
  // R4
  lead_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outClass == CLS_NUM) |-> (outMant[LeadPos] && outMant[MantW-1:LeadPos+1] == '0));
  // R7
  nan_form_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (outClass == CLS_QNAN || outClass == CLS_SNAN))
      |-> (outMant[LeadPos-1] && !outMant[LeadPos] && outExp == '0));
  // R6
  special_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (outClass == CLS_ZERO || outClass == CLS_INF)) |-> (outExp == '0 && outMant == '0));
  // R10
  sel_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outFmtErr) |-> (outClass == CLS_ZERO && !outInvalid && !outSign));
  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outMant) && $stable(outExp) && $stable(outClass) && !outValid));
endmodule

// File: rtl/fp_operand_unpack.sv
module fp_operand_unpack
  import fpu_unpack_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [2:0]   fmtSel,
  input  logic [127:0] operand,
  output logic         outValid,
  output logic         outSign,
  output logic [17:0]  outExp,
  output logic [127:0] outMant,
  output logic         outSticky,
  output logic [2:0]   outClass,
  output logic         outInvalid,
  output logic         outFmtErr
);
  unpackStrobeT         strobe;
  logic [ExpFieldW-1:0] expField;
  logic                 fracNonZero, quietBit, intNonZero;

  fp_unpack_ctrl ctrl_i (
    .fmtSel(fmtSel), .expField(expField), .fracNonZero(fracNonZero),
    .quietBit(quietBit), .intNonZero(intNonZero), .strobe(strobe)
  );

  fp_unpack_dp dp_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .fmtSel(fmtSel), .operand(operand),
    .strobe(strobe), .expField(expField), .fracNonZero(fracNonZero),
    .quietBit(quietBit), .intNonZero(intNonZero), .outValid(outValid),
    .outSign(outSign), .outExp(outExp), .outMant(outMant), .outClass(outClass),
    .outInvalid(outInvalid), .outFmtErr(outFmtErr)
  );

  assign outSticky = 1'b0;
endmodule

// File: tb/fp_operand_unpack_tb.sv
`timescale 1ns/1ps
module fp_operand_unpack_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [2:0]   fmtSel = 3'd0;
  logic [127:0] operand = '0;
  logic         outValid, outSign, outSticky, outInvalid, outFmtErr;
  logic [17:0]  outExp;
  logic [127:0] outMant;
  logic [2:0]   outClass;

  int testCount = 0;
  int failCount = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fp_operand_unpack dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .fmtSel(fmtSel), .operand(operand),
    .outValid(outValid), .outSign(outSign), .outExp(outExp), .outMant(outMant),
    .outSticky(outSticky), .outClass(outClass), .outInvalid(outInvalid), .outFmtErr(outFmtErr)
  );

  function automatic void fmtDims(input logic [2:0] f, output int e, output int fr);
    case (f)
      3'd1: begin e = 8;  fr = 23;  end
      3'd2: begin e = 11; fr = 52;  end
      default: begin e = 15; fr = 112; end
    endcase
  endfunction

  function automatic logic [127:0] packFp(input logic [2:0] f, input bit s,
                                          input int ex, input logic [127:0] frac);
    int e, fr;
    fmtDims(f, e, fr);
    return (128'(s) << 127) | (128'(ex) << (127 - e)) | (frac << (127 - e - fr));
  endfunction

  function automatic void model(input logic [2:0] f, input logic [127:0] op,
      output bit eSign, output logic [17:0] eExp, output logic [127:0] eMant,
      output logic [2:0] eCls, output bit eInv, output bit eErr, output string tag);
    int e, fr, bias, ef, p, ex;
    logic [127:0] frac, fmask;
    logic [31:0] mag;
    eSign = op[127]; eExp = '0; eMant = '0; eCls = 3'd0; eInv = 0; eErr = 0;
    if (f > 3'd3) begin
      eSign = 0; eErr = 1; tag = "R10"; return;
    end
    if (f == 3'd0) begin
      mag = op[127] ? -op[127:96] : op[127:96];
      if (mag == 0) begin tag = "R3"; return; end
      p = 0;
      for (int i = 0; i < 32; i++) if (mag[i]) p = i;
      eExp = 18'(p); eMant = 128'(mag) << (124 - p); eCls = 3'd1; tag = "R9";
      return;
    end
    fmtDims(f, e, fr);
    bias = (1 << (e - 1)) - 1;
    ef = int'(op[126:112]) >> (15 - e);
    fmask = (128'(1) << fr) - 1;
    frac = (op >> (127 - e - fr)) & fmask;
    if (ef == 0) begin
      if (frac == 0) begin tag = "R3"; return; end
      p = 0;
      for (int i = 0; i < 112; i++) if (i < fr && frac[i]) p = i;
      ex = 1 - bias - fr + p;
      eExp = 18'(ex); eMant = frac << (124 - p); eCls = 3'd1; tag = "R5";
    end else if (ef == (1 << e) - 1) begin
      if (frac == 0) begin eCls = 3'd2; tag = "R6"; return; end
      eMant = frac << (124 - fr);
      if (eMant[123]) begin eCls = 3'd3; tag = "R7"; end
      else begin eMant[123] = 1'b1; eCls = 3'd4; eInv = 1; tag = "R8"; end
    end else begin
      eExp = 18'(ef - bias);
      eMant = (frac | (128'(1) << fr)) << (124 - fr);
      eCls = 3'd1; tag = "R4";
    end
  endfunction

  task automatic checkNow(input logic [2:0] f, input logic [127:0] op, input string note);
    bit eSign, eInv, eErr;
    logic [17:0] eExp;
    logic [127:0] eMant;
    logic [2:0] eCls;
    string tag;
    model(f, op, eSign, eExp, eMant, eCls, eInv, eErr, tag);
    testCount++;
    if (outValid !== 1'b1 || outSign !== eSign || outExp !== eExp || outMant !== eMant ||
        outClass !== eCls || outInvalid !== eInv || outFmtErr !== eErr || outSticky !== 1'b0) begin
      failCount++;
      $display("FAIL %s (%s) fmt=%0d op=%h: got v=%b s=%b exp=%h mant=%h cls=%0d inv=%b err=%b stk=%b, expected v=1 s=%b exp=%h mant=%h cls=%0d inv=%b err=%b stk=0",
               tag, note, f, op, outValid, outSign, outExp, outMant, outClass, outInvalid,
               outFmtErr, outSticky, eSign, eExp, eMant, eCls, eInv, eErr);
    end
  endtask

  task automatic apply(input logic [2:0] f, input logic [127:0] op, input string note);
    @(negedge clk);
    inValid = 1'b1; fmtSel = f; operand = op;
    @(negedge clk);
    inValid = 1'b0;
    checkNow(f, op, note);
  endtask

  task automatic check1(input bit ok, input string msg);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    failCount++;
    $display("FAIL watchdog: got no end, expected completion");
    finish();
  end

  initial begin
    logic [127:0] savedMant;
    logic [17:0] savedExp;
    void'($urandom(32'd24681357));
    repeat (3) @(negedge clk);
    // R11 reset state
    check1(outValid === 0 && outSign === 0 && outExp === 0 && outMant === 0 &&
           outClass === 0 && outInvalid === 0 && outFmtErr === 0 && outSticky === 0,
           $sformatf("R11 reset: got v=%b cls=%0d mant=%h, expected all 0", outValid, outClass, outMant));
    rstN = 1'b1;

    // Directed corners for each float format (R2..R8)
    for (int f = 1; f <= 3; f++) begin
      int e, fr, emax, bias;
      logic [127:0] fones;
      fmtDims(3'(f), e, fr);
      emax = (1 << e) - 1; bias = (1 << (e - 1)) - 1;
      fones = (128'(1) << fr) - 1;
      apply(3'(f), packFp(3'(f), 0, 0, 0), "R3 zero");
      apply(3'(f), packFp(3'(f), 1, 0, 0), "R3 neg zero R2");
      apply(3'(f), packFp(3'(f), 0, 0, 1), "R5 min subnormal");
      apply(3'(f), packFp(3'(f), 1, 0, fones), "R5 max subnormal");
      apply(3'(f), packFp(3'(f), 0, bias, 0), "R4 one");
      apply(3'(f), packFp(3'(f), 1, bias, 0), "R4 minus one R2");
      apply(3'(f), packFp(3'(f), 0, emax - 1, fones), "R4 max normal");
      apply(3'(f), packFp(3'(f), 1, emax, 0), "R6 infinity");
      apply(3'(f), packFp(3'(f), 0, emax, 128'(1) << (fr - 1)), "R7 quiet NaN");
      apply(3'(f), packFp(3'(f), 0, emax, 1), "R8 signalling NaN");
      apply(3'(f), packFp(3'(f), 1, emax, fones >> 1), "R8 signalling NaN full");
    end
    // Integers (R9, R3)
    apply(3'd0, {32'h0000_0000, 96'h0}, "R3 int zero");
    apply(3'd0, {32'h0000_0001, 96'h0}, "R9 int one");
    apply(3'd0, {32'hFFFF_FFFF, 96'h0}, "R9 int minus one");
    apply(3'd0, {32'h8000_0000, 96'h0}, "R9 most negative");
    apply(3'd0, {32'h7FFF_FFFF, 96'h1234}, "R9 max positive");
    apply(3'd0, {32'h1F00_0000, 96'h0}, "R9 top bit 28");
    // Illegal selects (R10)
    apply(3'd4, {4{32'hDEAD_BEEF}}, "R10 sel 4");
    apply(3'd7, {4{32'hFFFF_FFFF}}, "R10 sel 7");

    // R1 hold: present a valid op, then change inputs with inValid low
    apply(3'd2, packFp(3'd2, 0, 1023, 5), "R1 load");
    savedMant = outMant; savedExp = outExp;
    fmtSel = 3'd1; operand = packFp(3'd1, 1, 0, 7);
    @(negedge clk);
    check1(outValid === 0 && outMant === savedMant && outExp === savedExp,
           $sformatf("R1 hold: got v=%b mant=%h exp=%h, expected v=0 mant=%h exp=%h",
                     outValid, outMant, outExp, savedMant, savedExp));

    // Random stimulus
    for (int n = 0; n < 800; n++) begin
      logic [2:0] f;
      logic [127:0] op, emask;
      int e, fr, k;
      k = int'($urandom % 12);
      f = (k < 11) ? 3'(k % 4) : 3'(4 + $urandom % 4);
      op = {$urandom, $urandom, $urandom, $urandom};
      if (f >= 3'd1 && f <= 3'd3) begin
        fmtDims(f, e, fr);
        emask = ((128'(1) << e) - 1) << (127 - e);
        k = int'($urandom % 4);
        if (k == 0) op = op & ~emask;
        else if (k == 1) op = op | emask;
        else if (k == 2) op = (op & ~emask) & ~((128'(1) << (127 - e - ($urandom % 4) - 1)) - 1);
      end
      apply(f, op, "random");
    end
    finish();
  end
endmodule